// File: doc/BRIEF.md
# Selectable-Dataflow 1-D Convolution Engine

This block is one processing element that computes a 'valid' one-dimensional convolution. A weight store of R entries and an activation store of H entries are filled through a shared load port. A start pulse then triggers E = H - R + 1 result sums, each formed as O[e] = sum over r of A[e+r]·W[r]. The results go into an internal result store, which is read back through a registered read port. The engine does one multiply-accumulate per active cycle. Operands come from register-modelled stores.

A mode code is sampled at start and picks one of three loop orderings over the same multiplier. Result-held ordering keeps the running sum in a local register. Weight-held ordering keeps one weight in a local register while it sweeps all outputs. Activation-held ordering keeps one activation while it scatters products into the outputs it feeds. All three orderings give the same results. Five counters record the weight reads, activation reads, result reads, result writes and MACs of the last run, so the orderings can be compared on buffer traffic.

Top module: `conv1d_engine`

## Requirements
- R1: After a run, reading result address e (0 to E-1) returns the signed sum over r of A[e+r]·W[r]. Weights and activations are signed two's complement, loaded with ld_sel=0 for weights and ld_sel=1 for activations. rd_data shows the entry addressed one clock edge earlier.
- R2: Starting a run clears every result entry to zero before accumulation. Stale values from an earlier run therefore never leak into a new result.
- R3: done is high for exactly one cycle. Counting the start edge as edge 0, done is high in the cycle that follows edge N. N is E·R for mode codes 0, 1 and 3, and H·R for mode code 2.
- R4: Mode code 0 (result-held) gives E·R weight reads, E·R activation reads, 0 result reads and E result writes.
- R5: Mode code 1 (weight-held) gives R weight reads, E·R activation reads, E·R result reads and E·R result writes.
- R6: Mode code 2 (activation-held) visits every (h, r) pair but skips pairs whose output index h-r lies outside 0 to E-1. It gives E·R weight reads, H activation reads, E·R result reads and E·R result writes.
- R7: Every mode performs exactly E·R MACs.
- R8: All modes give identical results for the same stored operands.
- R9: Mode code 3 behaves exactly like mode code 0, in both results and counts.
- R10: A start pulse while busy is high is ignored. The current run keeps its mode and timing.
- R11: Operands at the extreme values -2^(DW-1) and 2^(DW-1)-1 produce exact sums with no overflow.
- R12: The counters are cleared at start and keep their final values after done until the next accepted start.
- R13: busy rises in the cycle after an accepted start and stays high until the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when not busy |
| mode | input | 2 | Loop ordering: 0 result-held, 1 weight-held, 2 activation-held, 3 same as 0 |
| ld_en | input | 1 | Write one operand entry |
| ld_sel | input | 1 | 0 writes weight store, 1 writes activation store |
| ld_addr | input | IW | Operand entry index |
| ld_data | input | DW | Signed operand value |
| rd_addr | input | IW | Result entry to read |
| rd_data | output | AW | Registered signed result |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_w_rd | output | CW | Weight reads of the last run |
| cnt_i_rd | output | CW | Activation reads of the last run |
| cnt_o_rd | output | CW | Result reads of the last run |
| cnt_o_wr | output | CW | Result writes of the last run |
| cnt_mac | output | CW | MACs of the last run |

## Verification
Suppose a loop counter wraps at the wrong limit or the skip test for out-of-range pairs is wrong. Then done arrives on a different edge from the one the bench predicts, and at least one access count is off. Both are visible in the same run. A held weight, held activation or accumulator that is latched at the wrong inner step leaves every other counter correct, but it corrupts one or more result entries. That error appears when the results are read back after done. Comparing the orderings against one another on random and extreme operands then exposes a fault confined to a single mode.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [1:0] {
        DF_OS  = 2'd0,
        DF_WS  = 2'd1,
        DF_IS  = 2'd2,
        DF_RSV = 2'd3
    } dflow_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/conv_seq.sv
module conv_seq
    import conv_pkg::*;
#(
    parameter int H  = 12,
    parameter int R  = 4,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  dflow_e        mode,
    output logic [IW-1:0] e_idx,
    output logic [IW-1:0] r_idx,
    output logic [IW-1:0] i_idx,
    output logic          pair_ok,
    output logic          in_first,
    output logic          in_last,
    output logic          seq_last
);
    localparam int E = H - R + 1;
    localparam logic [IW-1:0] E_M1 = IW'(E - 1);
    localparam logic [IW-1:0] R_M1 = IW'(R - 1);
    localparam logic [IW-1:0] H_M1 = IW'(H - 1);
    localparam logic [IW-1:0] E_LIM = IW'(E);

    typedef struct packed {
        logic [IW-1:0] outer;
        logic [IW-1:0] inner;
    } seq_st_t;

    seq_st_t q, d;
    logic [IW-1:0] outer_end, inner_end, diff;

    always_comb begin
        d    = q;
        diff = q.outer - q.inner;
        case (mode)
            DF_WS: begin
                outer_end = R_M1;
                inner_end = E_M1;
                e_idx     = q.inner;
                r_idx     = q.outer;
                i_idx     = q.inner + q.outer;
                pair_ok   = 1'b1;
            end
            DF_IS: begin
                outer_end = H_M1;
                inner_end = R_M1;
                e_idx     = diff;
                r_idx     = q.inner;
                i_idx     = q.outer;
                pair_ok   = (q.outer >= q.inner) && (diff < E_LIM);
            end
            default: begin
                outer_end = E_M1;
                inner_end = R_M1;
                e_idx     = q.outer;
                r_idx     = q.inner;
                i_idx     = q.outer + q.inner;
                pair_ok   = 1'b1;
            end
        endcase
        in_first = (q.inner == '0);
        in_last  = (q.inner == inner_end);
        seq_last = in_last && (q.outer == outer_end);
        if (clear) begin
            d = '0;
        end else if (step) begin
            if (in_last) begin
                d.inner = '0;
                d.outer = seq_last ? '0 : q.outer + 1'b1;
            end else begin
                d.inner = q.inner + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/conv_mac.sv
module conv_mac
    import conv_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  dflow_e        mode,
    input  logic          in_first,
    input  logic          in_last,
    input  logic          pair_ok,
    input  logic [DW-1:0] w_val,
    input  logic [DW-1:0] i_val,
    input  logic [AW-1:0] o_val,
    output logic          rd_w,
    output logic          rd_i,
    output logic          rd_o,
    output logic          wr_o,
    output logic          mac_ev,
    output logic [AW-1:0] wr_val
);
    typedef struct packed {
        logic [AW-1:0] acc;
        logic [DW-1:0] whold;
        logic [DW-1:0] ihold;
    } mac_st_t;

    mac_st_t q, d;
    logic [DW-1:0]          w_op, i_op;
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_x, sum;

    always_comb begin
        d      = q;
        rd_w   = 1'b0;
        rd_i   = 1'b0;
        rd_o   = 1'b0;
        wr_o   = 1'b0;
        mac_ev = 1'b0;
        wr_val = '0;
        case (mode)
            DF_WS:   begin w_op = in_first ? w_val : q.whold; i_op = i_val; end
            DF_IS:   begin w_op = w_val; i_op = in_first ? i_val : q.ihold; end
            default: begin w_op = w_val; i_op = i_val; end
        endcase
        prod   = $signed(w_op) * $signed(i_op);
        prod_x = AW'(prod);
        sum    = in_first ? prod_x : $signed(q.acc) + prod_x;
        if (step) begin
            case (mode)
                DF_WS: begin
                    rd_w   = in_first;
                    rd_i   = 1'b1;
                    rd_o   = 1'b1;
                    wr_o   = 1'b1;
                    mac_ev = 1'b1;
                    wr_val = $signed(o_val) + prod_x;
                    if (in_first) d.whold = w_val;
                end
                DF_IS: begin
                    rd_i = in_first;
                    if (in_first) d.ihold = i_val;
                    if (pair_ok) begin
                        rd_w   = 1'b1;
                        rd_o   = 1'b1;
                        wr_o   = 1'b1;
                        mac_ev = 1'b1;
                        wr_val = $signed(o_val) + prod_x;
                    end
                end
                default: begin
                    rd_w   = 1'b1;
                    rd_i   = 1'b1;
                    mac_ev = 1'b1;
                    if (in_last) begin
                        wr_o   = 1'b1;
                        wr_val = sum;
                    end
                    d.acc = sum;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/conv_counters.sv
module conv_counters #(
    parameter int N  = 5,
    parameter int CW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [N-1:0]         inc,
    output logic [N-1:0][CW-1:0] cnt
);
    logic [N-1:0][CW-1:0] cnt_d, cnt_q;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            cnt_d[k] = clear ? '0 : cnt_q[k] + CW'(inc[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/conv1d_engine.sv
module conv1d_engine
    import conv_pkg::*;
#(
    parameter int DW = 8,
    parameter int H  = 12,
    parameter int R  = 4,
    parameter int E  = H - R + 1,
    parameter int IW = $clog2(H + 1),
    parameter int AW = 2 * DW + $clog2(R),
    parameter int CW = $clog2(H * R + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic          ld_en,
    input  logic          ld_sel,
    input  logic [IW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [IW-1:0] rd_addr,
    output logic [AW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt_w_rd,
    output logic [CW-1:0] cnt_i_rd,
    output logic [CW-1:0] cnt_o_rd,
    output logic [CW-1:0] cnt_o_wr,
    output logic [CW-1:0] cnt_mac
);
    localparam int NCNT = 5;

    typedef struct packed {
        eng_state_e           state;
        dflow_e               mode;
        logic [R-1:0][DW-1:0] wbuf;
        logic [H-1:0][DW-1:0] ibuf;
        logic [E-1:0][AW-1:0] obuf;
        logic [AW-1:0]        rd_data;
    } eng_st_t;

    eng_st_t q, d;
    logic go, step;
    logic [IW-1:0] e_idx, r_idx, i_idx;
    logic pair_ok, in_first, in_last, seq_last;
    logic [DW-1:0] w_val, i_val;
    logic [AW-1:0] o_val, wr_val;
    logic rd_w, rd_i, rd_o, wr_o, mac_ev;
    logic [NCNT-1:0][CW-1:0] cnt;
    logic [1:0] mode_lat;

    conv_seq #(.H(H), .R(R), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(go), .step(step), .mode(q.mode),
        .e_idx(e_idx), .r_idx(r_idx), .i_idx(i_idx), .pair_ok(pair_ok),
        .in_first(in_first), .in_last(in_last), .seq_last(seq_last)
    );

    conv_mac #(.DW(DW), .AW(AW)) u_mac (
        .clk(clk), .rst_n(rst_n), .step(step), .mode(q.mode),
        .in_first(in_first), .in_last(in_last), .pair_ok(pair_ok),
        .w_val(w_val), .i_val(i_val), .o_val(o_val),
        .rd_w(rd_w), .rd_i(rd_i), .rd_o(rd_o), .wr_o(wr_o),
        .mac_ev(mac_ev), .wr_val(wr_val)
    );

    conv_counters #(.N(NCNT), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(go),
        .inc({mac_ev, wr_o, rd_o, rd_i, rd_w}), .cnt(cnt)
    );

    always_comb begin
        d     = q;
        go    = start && (q.state != ST_RUN);
        step  = (q.state == ST_RUN);
        w_val = '0;
        i_val = '0;
        o_val = '0;
        for (int k = 0; k < R; k++) if (r_idx == IW'(k)) w_val = q.wbuf[k];
        for (int k = 0; k < H; k++) if (i_idx == IW'(k)) i_val = q.ibuf[k];
        for (int k = 0; k < E; k++) if (e_idx == IW'(k)) o_val = q.obuf[k];
        if (ld_en) begin
            if (ld_sel) begin
                for (int k = 0; k < H; k++) if (ld_addr == IW'(k)) d.ibuf[k] = ld_data;
            end else begin
                for (int k = 0; k < R; k++) if (ld_addr == IW'(k)) d.wbuf[k] = ld_data;
            end
        end
        d.rd_data = '0;
        for (int k = 0; k < E; k++) if (rd_addr == IW'(k)) d.rd_data = q.obuf[k];
        case (q.state)
            ST_RUN: begin
                if (wr_o) begin
                    for (int k = 0; k < E; k++) if (e_idx == IW'(k)) d.obuf[k] = wr_val;
                end
                if (seq_last) d.state = ST_FIN;
            end
            ST_FIN:  d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
        if (go) begin
            d.state = ST_RUN;
            d.mode  = (dflow_e'(mode) == DF_RSV) ? DF_OS : dflow_e'(mode);
            d.obuf  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data  = q.rd_data;
    assign busy     = (q.state == ST_RUN);
    assign done     = (q.state == ST_FIN);
    assign mode_lat = q.mode;
    assign cnt_w_rd = cnt[0];
    assign cnt_i_rd = cnt[1];
    assign cnt_o_rd = cnt[2];
    assign cnt_o_wr = cnt[3];
    assign cnt_mac  = cnt[4];
endmodule

// File: rtl/conv1d_engine_chk.sv
module conv1d_engine_chk #(
    parameter int H  = 12,
    parameter int R  = 4,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [1:0]    mode_lat,
    input logic [CW-1:0] cnt_w_rd,
    input logic [CW-1:0] cnt_o_rd,
    input logic [CW-1:0] cnt_mac
);
    localparam int E = H - R + 1;

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r7_mac_total: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_mac == CW'(E * R)));

    a_r4_os_no_result_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lat == 2'd0) |-> (cnt_o_rd == '0));

    a_r5_ws_weight_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_lat == 2'd1) |-> (cnt_w_rd == CW'(R)));

    a_r12_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(cnt_mac) && $stable(cnt_w_rd)));
endmodule

bind conv1d_engine conv1d_engine_chk #(.H(H), .R(R), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mode_lat(mode_lat), .cnt_w_rd(cnt_w_rd), .cnt_o_rd(cnt_o_rd),
    .cnt_mac(cnt_mac)
);

// File: tb/conv1d_engine_tb_top.sv
module conv1d_engine_tb_top;
    localparam int DW = 8;
    localparam int H  = 12;
    localparam int R  = 4;
    localparam int E  = H - R + 1;
    localparam int IW = $clog2(H + 1);
    localparam int AW = 2 * DW + $clog2(R);
    localparam int CW = $clog2(H * R + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = '0;
    logic ld_en = 1'b0, ld_sel = 1'b0;
    logic [IW-1:0] ld_addr = '0, rd_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [AW-1:0] rd_data;
    logic busy, done;
    logic [CW-1:0] cnt_w_rd, cnt_i_rd, cnt_o_rd, cnt_o_wr, cnt_mac;

    int nchk = 0;
    int nfail = 0;
    int wv[R];
    int iv[H];
    int ref_o[E];
    int got[E];

    always #5 clk = ~clk;

    conv1d_engine #(.DW(DW), .H(H), .R(R)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .cnt_w_rd(cnt_w_rd), .cnt_i_rd(cnt_i_rd), .cnt_o_rd(cnt_o_rd),
        .cnt_o_wr(cnt_o_wr), .cnt_mac(cnt_mac)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model();
        for (int e = 0; e < E; e++) begin
            ref_o[e] = 0;
            for (int r = 0; r < R; r++) ref_o[e] += iv[e + r] * wv[r];
        end
    endfunction

    task automatic load_all();
        for (int k = 0; k < R; k++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_sel = 1'b0; ld_addr = IW'(k); ld_data = DW'(wv[k]);
        end
        for (int k = 0; k < H; k++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_sel = 1'b1; ld_addr = IW'(k); ld_data = DW'(iv[k]);
        end
        @(negedge clk);
        ld_en = 1'b0;
        model();
    endtask

    task automatic read_all();
        for (int e = 0; e < E; e++) begin
            @(negedge clk);
            rd_addr = IW'(e);
            @(negedge clk);
            got[e] = int'($signed(rd_data));
        end
    endtask

    // Runs one job, checks R3/R13 timing, counters (R4-R7, R9, R12) and results (R1, R8).
    task automatic run(input int m, input bit intrude, input string tag);
        int edges, n, ew, ei, eor, eow;
        edges = 0;
        @(negedge clk);
        start = 1'b1; mode = 2'(m);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R13 busy after start", busy, 1);
        while (!done && edges < 1000) begin
            if (intrude && edges == 5) begin start = 1'b1; mode = 2'd2; end
            else start = 1'b0;
            @(negedge clk);
            edges++;
            if (!done) chk(busy == 1'b1, "R13 busy until done", busy, 1);
        end
        start = 1'b0;
        n = (m == 2) ? H * R : E * R;
        chk(edges == n, {tag, " R3 done edge"}, edges, n);
        if (intrude) chk(edges == n, "R10 restart ignored", edges, n);
        @(negedge clk);
        chk(done == 1'b0, "R3 done single cycle", done, 0);
        repeat (3) @(negedge clk);
        case (m)
            1:       begin ew = R;     ei = E * R; eor = E * R; eow = E * R; end
            2:       begin ew = E * R; ei = H;     eor = E * R; eow = E * R; end
            default: begin ew = E * R; ei = E * R; eor = 0;     eow = E;     end
        endcase
        chk(cnt_w_rd == CW'(ew),  {tag, " R4 R5 R6 R9 weight reads"}, cnt_w_rd, ew);
        chk(cnt_i_rd == CW'(ei),  {tag, " R4 R5 R6 R9 activation reads"}, cnt_i_rd, ei);
        chk(cnt_o_rd == CW'(eor), {tag, " R4 R5 R6 R9 result reads"}, cnt_o_rd, eor);
        chk(cnt_o_wr == CW'(eow), {tag, " R4 R5 R6 R9 result writes"}, cnt_o_wr, eow);
        chk(cnt_mac == CW'(E * R), {tag, " R7 R12 mac count held"}, cnt_mac, E * R);
        read_all();
        for (int e = 0; e < E; e++)
            chk(got[e] == ref_o[e], {tag, " R1 R8 result"}, got[e], ref_o[e]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "reset idle", {busy, done}, 0);
        chk(cnt_mac == '0, "reset counters", cnt_mac, 0);

        // Random operands, every mode (R1, R4-R8)
        for (int t = 0; t < 3; t++) begin
            for (int k = 0; k < R; k++) wv[k] = int'($urandom_range(255)) - 128;
            for (int k = 0; k < H; k++) iv[k] = int'($urandom_range(255)) - 128;
            load_all();
            for (int m = 0; m < 3; m++) run(m, 1'b0, "random");
        end
        // R9: reserved code behaves as result-held
        run(3, 1'b0, "R9 code3");
        // R10: start during a run is ignored
        run(0, 1'b1, "R10 intrude");
        // R11: extremes, all most-negative, then mixed
        for (int k = 0; k < R; k++) wv[k] = -128;
        for (int k = 0; k < H; k++) iv[k] = -128;
        load_all();
        for (int m = 0; m < 3; m++) run(m, 1'b0, "R11 min");
        for (int k = 0; k < R; k++) wv[k] = (k % 2 == 0) ? 127 : -128;
        for (int k = 0; k < H; k++) iv[k] = (k % 2 == 0) ? 127 : -128;
        load_all();
        run(1, 1'b0, "R11 mixed");
        // R2: zero weights after nonzero results, accumulating modes
        for (int k = 0; k < R; k++) wv[k] = 0;
        load_all();
        run(1, 1'b0, "R2 clear ws");
        run(2, 1'b0, "R2 clear is");
        // R12: counters still held after idle cycles
        repeat (10) @(negedge clk);
        chk(cnt_w_rd == CW'(E * R), "R12 counts kept idle", cnt_w_rd, E * R);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule